// File: doc/BRIEF.md
# NAND Command Cycle Sequencer

This block turns one packed control word, written by a host through a small word-indexed register port, into a complete sequence of cycles on a raw 8-bit NAND flash bus. It drives the command latch enable, address latch enable, write strobe, read strobe and two chip enables, and it watches the ready/busy line. A sequence begins with a first opcode cycle and continues with zero to five address cycles, taken from two address registers with the lowest byte first. An optional confirm opcode follows, then a guarded wait for the device to become ready. The last step is an optional data phase that moves a programmed number of bytes between the flash bus and a byte stream port.

The host loads the confirm, address and length registers, then writes the control word with its valid bit set. The block copies every field when the sequence starts, so these registers can be reloaded for the next operation while one is running. When the sequence ends, sticky interrupt bits report completion and, if bytes moved, data-transfer completion. The host clears them by writing ones. A status bit reports that a sequence is running, and control writes that arrive during a sequence are dropped.

Top module: `nand_cmd_seq`

## Requirements
- R1: After reset, and whenever no sequence runs, both chip enables are high (`nand_ce_n` = 2'b11), the write and read strobes are high, CLE and ALE are low, the bus is not driven, the interrupt bits and `irq` are 0, and status bit 0 (busy) is 0.
- R2: A write to register index 0 (control) with bit 31 set starts a sequence whose first bus cycle is a command cycle (CLE high) carrying control bits 7:0. A control write with bit 31 clear starts nothing.
- R3: Control bits 30:27 set the address cycles: bit 30 enables them and bits 29:27 hold the byte count minus one. Values 0 to 4 give 1 to 5 bytes and values 5 to 7 give 5 bytes. With bit 30 clear there are no address cycles. Address cycles have ALE high and follow the first command.
- R4: Address bytes are sent in the order index2[7:0], index2[15:8], index3[7:0], index3[15:8], index3[23:16], where register index 2 holds 16 bits and index 3 holds 24 bits.
- R5: Control bit 19 selects the chip enable for the whole sequence: 0 drives `nand_ce_n[0]` low, 1 drives `nand_ce_n[1]` low, and the other enable stays high.
- R6: Register index 1 holds a confirm opcode in bits 7:0 and an enable in bit 8. When the enable is set, a command cycle with that opcode follows the address cycles. When it is clear, no such cycle is issued.
- R7: After the last command or address cycle, the sequencer waits at least TWB clocks and then waits for `nand_rb` high. No data cycle occurs and the done bit stays clear while `nand_rb` is low.
- R8: With control bit 26 set (and regardless of bit 25), the data phase performs as many read strobes as register index 4 holds. Each sampled bus byte appears once on `rd_byte` with `rd_valid`, in bus order.
- R9: With bit 25 set and bit 26 clear, each data byte is taken from `wr_byte` in the cycle `wr_take` pulses. It is then written with a write strobe while CLE and ALE are low, once per counted byte.
- R10: A length of zero, or a control word with neither bit 25 nor bit 26 set, skips the data phase: no data cycles occur and interrupt bit 28 is not set.
- R11: Register index 5 holds the interrupt bits. Bit 31 (done) is set in the cycle the sequence ends. Bit 28 (data done) is set when a data phase moved at least one byte. Both bits stay set until a write to index 5 with a one in that position, and `irq` is their OR.
- R12: Status register index 6 bit 0 is high from the control write until the sequence ends. A control write made while it is high is ignored entirely: no restart, and the stored control word is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq | output | 1 | OR of the sticky interrupt bits |
| wr_byte | input | 8 | Next byte for a write data phase |
| wr_take | output | 1 | `wr_byte` is consumed this cycle |
| rd_byte | output | 8 | Byte read from the flash |
| rd_valid | output | 1 | `rd_byte` is valid this cycle |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_ce_n | output | 2 | Chip enables, active low |
| nand_dq_o | output | 8 | Bus data driven to the flash |
| nand_dq_oe | output | 1 | Bus output enable |
| nand_dq_i | input | 8 | Bus data from the flash |
| nand_rb | input | 1 | Ready/busy, high when ready |

## Verification
The hardest situation to reach is a control write that lands while a sequence is stalled on a busy flash. The write must be dropped, and the stall must hold back both the data phase and the done bit. The bench holds `nand_rb` low before it starts a read sequence. During the stall it issues a second valid control write and checks busy, the interrupt bits and the strobe counts. It then releases the line and confirms that only the first sequence's cycles reached the bus. Address handling is swept over every value of the address-count field, comparing the logged bus cycles with byte positions computed in the bench.

// File: rtl/nseq_pkg.sv
// Shared types and helpers for the NAND command sequencer.
// Assumes: register indices and control-word bit positions are fixed here.
package nseq_pkg;

    typedef enum logic [2:0] {
        S_IDLE, S_CMD1, S_ADDR, S_CMD2, S_WAIT, S_DATA
    } seq_state_t;

    typedef enum logic [1:0] {
        BK_CMD, BK_ADR, BK_WR, BK_RD
    } bus_kind_t;

    localparam logic [2:0] IDX_CTRL    = 3'd0;
    localparam logic [2:0] IDX_CONFIRM = 3'd1;
    localparam logic [2:0] IDX_ADLO    = 3'd2;
    localparam logic [2:0] IDX_ADHI    = 3'd3;
    localparam logic [2:0] IDX_LEN     = 3'd4;
    localparam logic [2:0] IDX_IRQ     = 3'd5;
    localparam logic [2:0] IDX_STATUS  = 3'd6;

    localparam int CB_VALID = 31;
    localparam int CB_RD    = 26;
    localparam int CB_WR    = 25;
    localparam int CB_CS    = 19;
    localparam int IB_DONE  = 31;
    localparam int IB_XFER  = 28;

    // Decode the 4-bit address field into a byte count of 0..5.
    function automatic logic [2:0] adr_bytes(input logic [3:0] f);
        if (!f[3])
            return 3'd0;
        else if (f[2:0] >= 3'd4)
            return 3'd5;
        else
            return 3'(f[2:0] + 3'd1);
    endfunction

endpackage

// File: rtl/nseq_bus.sv
// Single NAND bus cycle engine.
// Runs one command, address, write or read cycle per start pulse: the strobe
// is low for PULSE clocks and then high for PULSE clocks. Read data is
// sampled in the last low clock of the read strobe.
// Assumes: start is only pulsed while no cycle is active.
module nseq_bus
    import nseq_pkg::*;
#(
    parameter int PULSE = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  bus_kind_t  kind_i,
    input  logic [7:0] byte_i,
    input  logic [7:0] dq_i,
    output logic       done,
    output logic       rd_valid,
    output logic [7:0] rd_byte,
    output logic       cle,
    output logic       ale,
    output logic       we_n,
    output logic       re_n,
    output logic [7:0] dq_o,
    output logic       dq_oe
);

    localparam int LAST = 2 * PULSE - 1;
    localparam int PH_W = (LAST < 1) ? 1 : $clog2(LAST + 1);

    logic            active_q;
    logic [PH_W-1:0] ph_q;
    bus_kind_t       kind_q;
    logic [7:0]      byte_q;
    logic [7:0]      rdb_q;
    logic            low_ph;

    // Phase counter and latched cycle parameters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            ph_q     <= '0;
            kind_q   <= BK_CMD;
            byte_q   <= 8'h00;
        end else if (start) begin
            active_q <= 1'b1;
            ph_q     <= '0;
            kind_q   <= kind_i;
            byte_q   <= byte_i;
        end else if (active_q) begin
            if (ph_q == PH_W'(LAST))
                active_q <= 1'b0;
            else
                ph_q <= ph_q + 1'b1;
        end
    end

    // Capture read data at the end of the read strobe low time.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdb_q <= 8'h00;
        else if (active_q && kind_q == BK_RD && ph_q == PH_W'(PULSE - 1))
            rdb_q <= dq_i;
    end

    // Pin and handshake decode.
    always_comb begin
        low_ph   = active_q && (ph_q < PH_W'(PULSE));
        done     = active_q && (ph_q == PH_W'(LAST));
        rd_valid = done && (kind_q == BK_RD);
        rd_byte  = rdb_q;
        cle      = active_q && (kind_q == BK_CMD);
        ale      = active_q && (kind_q == BK_ADR);
        we_n     = !(low_ph && kind_q != BK_RD);
        re_n     = !(low_ph && kind_q == BK_RD);
        dq_o     = byte_q;
        dq_oe    = active_q && (kind_q != BK_RD);
    end

    AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !active_q); // R2

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !re_n)); // R8

endmodule

// File: rtl/nseq_ctrl.sv
// Sequence controller.
// Latches the command fields on go, then steps through first command,
// address bytes, optional confirm, ready wait and optional data phase,
// issuing one bus cycle per step through nseq_bus.
// Assumes: go is a one-cycle pulse that only arrives while idle.
module nseq_ctrl
    import nseq_pkg::*;
#(
    parameter int LEN_W = 12,
    parameter int TWB   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [31:0]      ctrl_w,
    input  logic [8:0]       conf_w,
    input  logic [15:0]      alo_w,
    input  logic [23:0]      ahi_w,
    input  logic [LEN_W-1:0] len_w,
    input  logic             bus_done,
    input  logic [7:0]       wr_byte,
    input  logic             nand_rb,
    output logic             bus_start,
    output bus_kind_t        bus_kind,
    output logic [7:0]       bus_byte,
    output logic             wr_take,
    output logic [1:0]       ce_n,
    output logic             busy,
    output logic             fin_evt,
    output logic             xfer_evt
);

    localparam int TW_W = $clog2(TWB + 1);

    seq_state_t       state_q;
    logic             issued_q;
    logic [7:0]       op1_q;
    logic             rd_q;
    logic             wr_q;
    logic             cs_q;
    logic             cf_en_q;
    logic [7:0]       cf_op_q;
    logic [2:0]       adr_left_q;
    logic [39:0]      adr_sh_q;
    logic [LEN_W-1:0] len_q;
    logic [TW_W-1:0]  twb_q;
    logic             has_data;
    logic             wait_go;
    logic             last_data;
    seq_state_t       after_adr;

    // Step decode and bus request generation.
    always_comb begin
        has_data  = (rd_q || wr_q) && (len_q != '0);
        wait_go   = (twb_q == TW_W'(TWB)) && nand_rb;
        last_data = (state_q == S_DATA) && bus_done && (len_q == LEN_W'(1));
        fin_evt   = ((state_q == S_WAIT) && wait_go && !has_data) || last_data;
        xfer_evt  = last_data;
        after_adr = cf_en_q ? S_CMD2 : S_WAIT;
        busy      = (state_q != S_IDLE);
        ce_n      = busy ? (cs_q ? 2'b01 : 2'b10) : 2'b11;
        bus_start = !issued_q && (state_q == S_CMD1 || state_q == S_ADDR ||
                                  state_q == S_CMD2 || state_q == S_DATA);
        wr_take   = bus_start && (state_q == S_DATA) && !rd_q;
        case (state_q)
            S_ADDR:  begin bus_kind = BK_ADR; bus_byte = adr_sh_q[7:0]; end
            S_CMD2:  begin bus_kind = BK_CMD; bus_byte = cf_op_q;       end
            S_DATA:  begin
                bus_kind = rd_q ? BK_RD : BK_WR;
                bus_byte = wr_byte;
            end
            default: begin bus_kind = BK_CMD; bus_byte = op1_q;         end
        endcase
    end

    // Sequence state, latched fields and counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            issued_q   <= 1'b0;
            op1_q      <= 8'h00;
            rd_q       <= 1'b0;
            wr_q       <= 1'b0;
            cs_q       <= 1'b0;
            cf_en_q    <= 1'b0;
            cf_op_q    <= 8'h00;
            adr_left_q <= 3'd0;
            adr_sh_q   <= '0;
            len_q      <= '0;
            twb_q      <= '0;
        end else begin
            if (bus_start)
                issued_q <= 1'b1;
            if (bus_done)
                issued_q <= 1'b0;
            if (state_q != S_WAIT)
                twb_q <= '0;
            case (state_q)
                S_IDLE: if (go) begin
                    state_q    <= S_CMD1;
                    issued_q   <= 1'b0;
                    op1_q      <= ctrl_w[7:0];
                    rd_q       <= ctrl_w[CB_RD];
                    wr_q       <= ctrl_w[CB_WR];
                    cs_q       <= ctrl_w[CB_CS];
                    cf_en_q    <= conf_w[8];
                    cf_op_q    <= conf_w[7:0];
                    adr_left_q <= adr_bytes(ctrl_w[30:27]);
                    adr_sh_q   <= {ahi_w, alo_w};
                    len_q      <= len_w;
                end
                S_CMD1: if (bus_done)
                    state_q <= (adr_left_q != 3'd0) ? S_ADDR : after_adr;
                S_ADDR: if (bus_done) begin
                    adr_sh_q   <= adr_sh_q >> 8;
                    adr_left_q <= adr_left_q - 3'd1;
                    if (adr_left_q == 3'd1)
                        state_q <= after_adr;
                end
                S_CMD2: if (bus_done)
                    state_q <= S_WAIT;
                S_WAIT: begin
                    if (twb_q != TW_W'(TWB))
                        twb_q <= twb_q + 1'b1;
                    else if (nand_rb)
                        state_q <= has_data ? S_DATA : S_IDLE;
                end
                S_DATA: if (bus_done) begin
                    len_q <= len_q - 1'b1;
                    if (len_q == LEN_W'(1))
                        state_q <= S_IDLE;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    AST_CE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE && $past(state_q) != S_IDLE) |-> $stable(ce_n)); // R5

    AST_ADDR_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ADDR) |-> (adr_left_q != 3'd0)); // R3

    AST_RB_BEFORE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DATA && $past(state_q) == S_WAIT) |-> $past(nand_rb)); // R7

    AST_TWB_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == S_WAIT && state_q != S_WAIT) |-> ($past(twb_q) == TW_W'(TWB))); // R7

endmodule

// File: rtl/nseq_regs.sv
// Host register file.
// Holds the control, confirm, address and length registers, the sticky
// interrupt bits and the read mux. A control write with the valid bit set
// while idle produces a registered go pulse.
// Assumes: busy_i covers the cycle between the control write and the start.
module nseq_regs
    import nseq_pkg::*;
#(
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [2:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    input  logic             busy_i,
    input  logic             fin_evt,
    input  logic             xfer_evt,
    output logic [31:0]      reg_rdata,
    output logic             go,
    output logic [31:0]      ctrl_q,
    output logic [8:0]       conf_q,
    output logic [15:0]      alo_q,
    output logic [23:0]      ahi_q,
    output logic [LEN_W-1:0] len_q,
    output logic             irq_done,
    output logic             irq_xfer
);

    logic wr_ctrl;
    logic wr_irq;

    always_comb begin
        wr_ctrl = reg_wr && (reg_addr == IDX_CTRL) && !busy_i;
        wr_irq  = reg_wr && (reg_addr == IDX_IRQ);
    end

    // Configuration registers and the start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            conf_q <= '0;
            alo_q  <= '0;
            ahi_q  <= '0;
            len_q  <= '0;
            go     <= 1'b0;
        end else begin
            go <= wr_ctrl && reg_wdata[CB_VALID];
            if (wr_ctrl)
                ctrl_q <= {1'b0, reg_wdata[30:0]};
            if (reg_wr && reg_addr == IDX_CONFIRM)
                conf_q <= reg_wdata[8:0];
            if (reg_wr && reg_addr == IDX_ADLO)
                alo_q <= reg_wdata[15:0];
            if (reg_wr && reg_addr == IDX_ADHI)
                ahi_q <= reg_wdata[23:0];
            if (reg_wr && reg_addr == IDX_LEN)
                len_q <= reg_wdata[LEN_W-1:0];
        end
    end

    // Sticky interrupt bits: set wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_done <= 1'b0;
            irq_xfer <= 1'b0;
        end else begin
            irq_done <= fin_evt  || (irq_done && !(wr_irq && reg_wdata[IB_DONE]));
            irq_xfer <= xfer_evt || (irq_xfer && !(wr_irq && reg_wdata[IB_XFER]));
        end
    end

    // Read mux.
    always_comb begin
        case (reg_addr)
            IDX_CTRL:    reg_rdata = ctrl_q;
            IDX_CONFIRM: reg_rdata = {23'd0, conf_q};
            IDX_ADLO:    reg_rdata = {16'd0, alo_q};
            IDX_ADHI:    reg_rdata = {8'd0, ahi_q};
            IDX_LEN:     reg_rdata = 32'(len_q);
            IDX_IRQ:     reg_rdata = {irq_done, 2'b00, irq_xfer, 28'd0};
            IDX_STATUS:  reg_rdata = {31'd0, busy_i};
            default:     reg_rdata = 32'd0;
        endcase
    end

    AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy_i && reg_wr && reg_addr == IDX_CTRL) |-> ($stable(ctrl_q) && !go)); // R12

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(irq_done) && !$past(reg_wr && reg_addr == IDX_IRQ && reg_wdata[IB_DONE]))
        |-> irq_done); // R11

endmodule

// File: rtl/nand_cmd_seq.sv
// NAND command cycle sequencer top.
// Connects the register file, the sequence controller and the bus cycle
// engine. The busy seen by the host includes the go cycle, so a second
// control write cannot slip in before the controller leaves idle.
// Assumes: nand_rb is already synchronous to clk.
module nand_cmd_seq
    import nseq_pkg::*;
#(
    parameter int LEN_W = 12,
    parameter int PULSE = 2,
    parameter int TWB   = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq,
    input  logic [7:0]  wr_byte,
    output logic        wr_take,
    output logic [7:0]  rd_byte,
    output logic        rd_valid,
    output logic        nand_cle,
    output logic        nand_ale,
    output logic        nand_we_n,
    output logic        nand_re_n,
    output logic [1:0]  nand_ce_n,
    output logic [7:0]  nand_dq_o,
    output logic        nand_dq_oe,
    input  logic [7:0]  nand_dq_i,
    input  logic        nand_rb
);

    logic             go;
    logic [31:0]      ctrl_q;
    logic [8:0]       conf_q;
    logic [15:0]      alo_q;
    logic [23:0]      ahi_q;
    logic [LEN_W-1:0] len_q;
    logic             irq_done;
    logic             irq_xfer;
    logic             seq_busy;
    logic             busy;
    logic             fin_evt;
    logic             xfer_evt;
    logic             bus_start;
    bus_kind_t        bus_kind;
    logic [7:0]       bus_byte;
    logic             bus_done;

    // Host-visible busy and interrupt output.
    always_comb begin
        busy = seq_busy || go;
        irq  = irq_done || irq_xfer;
    end

    nseq_regs #(.LEN_W(LEN_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .busy_i    (busy),
        .fin_evt   (fin_evt),
        .xfer_evt  (xfer_evt),
        .reg_rdata (reg_rdata),
        .go        (go),
        .ctrl_q    (ctrl_q),
        .conf_q    (conf_q),
        .alo_q     (alo_q),
        .ahi_q     (ahi_q),
        .len_q     (len_q),
        .irq_done  (irq_done),
        .irq_xfer  (irq_xfer)
    );

    nseq_ctrl #(.LEN_W(LEN_W), .TWB(TWB)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .ctrl_w    (ctrl_q),
        .conf_w    (conf_q),
        .alo_w     (alo_q),
        .ahi_w     (ahi_q),
        .len_w     (len_q),
        .bus_done  (bus_done),
        .wr_byte   (wr_byte),
        .nand_rb   (nand_rb),
        .bus_start (bus_start),
        .bus_kind  (bus_kind),
        .bus_byte  (bus_byte),
        .wr_take   (wr_take),
        .ce_n      (nand_ce_n),
        .busy      (seq_busy),
        .fin_evt   (fin_evt),
        .xfer_evt  (xfer_evt)
    );

    nseq_bus #(.PULSE(PULSE)) u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (bus_start),
        .kind_i   (bus_kind),
        .byte_i   (bus_byte),
        .dq_i     (nand_dq_i),
        .done     (bus_done),
        .rd_valid (rd_valid),
        .rd_byte  (rd_byte),
        .cle      (nand_cle),
        .ale      (nand_ale),
        .we_n     (nand_we_n),
        .re_n     (nand_re_n),
        .dq_o     (nand_dq_o),
        .dq_oe    (nand_dq_oe)
    );

    AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_done) |-> $fell(seq_busy)); // R11

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (nand_we_n && nand_re_n && nand_ce_n == 2'b11 && !nand_dq_oe)); // R1

endmodule

// File: tb/sim_nand_cmd_seq.sv
`timescale 1ns/1ps
module sim_nand_cmd_seq;

    localparam int TWB = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic [7:0]  wr_byte;
    logic        wr_take;
    logic [7:0]  rd_byte;
    logic        rd_valid;
    logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [1:0]  nand_ce_n;
    logic [7:0]  nand_dq_o;
    logic [7:0]  nand_dq_i = 8'h00;
    logic        nand_rb = 1'b1;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 0;
    bit mon_on = 0;

    logic [9:0] lg [0:255];
    int ln = 0;
    int rc = 0;
    logic [7:0] rbuf [0:63];
    int rn = 0;
    int widx = 0;
    int ce_bad = 0;
    logic [1:0] exp_ce = 2'b10;
    time t_we = 0;
    time t_re = 0;

    always #10 clk = ~clk;

    nand_cmd_seq u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .wr_byte(wr_byte), .wr_take(wr_take), .rd_byte(rd_byte), .rd_valid(rd_valid),
        .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
        .nand_re_n(nand_re_n), .nand_ce_n(nand_ce_n), .nand_dq_o(nand_dq_o),
        .nand_dq_oe(nand_dq_oe), .nand_dq_i(nand_dq_i), .nand_rb(nand_rb)
    );

    function automatic logic [7:0] pat_rd(input int k);
        return 8'(32'h3C + k * 7);
    endfunction

    function automatic logic [7:0] pat_wr(input int k);
        return 8'(32'h91 ^ (k * 5));
    endfunction

    assign wr_byte = pat_wr(widx);

    // Flash model: log write-strobe cycles, serve read strobes.
    always @(posedge nand_we_n) if (mon_on) begin
        lg[ln[7:0]] = {nand_cle, nand_ale, nand_dq_o};
        ln = ln + 1;
        t_we = $time;
    end

    always @(negedge nand_re_n) if (mon_on) begin
        nand_dq_i = pat_rd(rc);
        rc = rc + 1;
        t_re = $time;
    end

    always @(posedge clk) begin
        if (rd_valid) begin
            rbuf[rn[5:0]] <= rd_byte;
            rn <= rn + 1;
        end
        if (wr_take)
            widx <= widx + 1;
    end

    always @(negedge clk) if (mon_on && (!nand_we_n || !nand_re_n) && nand_ce_n != exp_ce)
        ce_bad = ce_bad + 1;

    // Watchdog.
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            total = total + 1;
            bad = bad + 1;
            $display("FAIL watchdog: act=%0d cycles exp=<150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wreg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rreg(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle;
        logic [31:0] s;
        for (int i = 0; i < 5000; i++) begin
            rreg(3'd6, s);
            if (s[0] == 1'b0) break;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic run(input logic [31:0] ctrl, input logic [8:0] conf,
                       input logic [31:0] len);
        wreg(3'd2, 32'h0000_B2A1);
        wreg(3'd3, 32'h00E5_D4C3);
        wreg(3'd1, 32'(conf));
        wreg(3'd4, len);
        wreg(3'd0, ctrl);
        wait_idle();
    endtask

    function automatic logic [7:0] adr_byte(input int i);
        logic [39:0] a;
        a = 40'hE5D4C3B2A1;
        return a[8*i +: 8];
    endfunction

    initial begin
        logic [31:0] v;
        int base, rbase, wbase, rcb, n;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        mon_on = 1;

        // R1: idle pins and registers after reset
        chk("R1 ce_n", 32'(nand_ce_n), 32'd3);
        chk("R1 strobes", {30'd0, nand_we_n, nand_re_n}, 32'd3);
        chk("R1 cle/ale/oe", {29'd0, nand_cle, nand_ale, nand_dq_oe}, 32'd0);
        rreg(3'd5, v); chk("R1 irq bits", v, 32'd0);
        chk("R1 irq pin", 32'(irq), 32'd0);
        rreg(3'd6, v); chk("R1 busy", v, 32'd0);

        // R2: control write without the valid bit starts nothing
        base = ln;
        wreg(3'd0, 32'h4000_0070);
        repeat (20) @(negedge clk);
        rreg(3'd6, v); chk("R2 no start busy", v, 32'd0);
        chk("R2 no start cycles", 32'(ln - base), 32'd0);

        // R3 R4 R10 R11: sweep the address field, no data phase
        for (int f = 0; f < 8; f++) begin
            n = (f >= 4) ? 5 : f + 1;
            base = ln;
            run(32'h8000_0000 | 32'h4000_0000 | (32'(f) << 27) | 32'(8'h10 + f), 9'h000, 32'd0);
            chk("R3 cycle count", 32'(ln - base), 32'(1 + n));
            chk("R2 first command", 32'(lg[base[7:0]]), {22'd0, 2'b10, 8'(8'h10 + f)});
            for (int i = 0; i < n; i++)
                chk("R4 address byte", 32'(lg[8'(base + 1 + i)]), {22'd0, 2'b01, adr_byte(i)});
            rreg(3'd5, v); chk("R10 R11 irq done only", v, 32'h8000_0000);
            wreg(3'd5, 32'h9000_0000);
        end
        chk("R5 ce0 held", 32'(ce_bad), 32'd0);

        // R3: enable bit clear gives no address cycles
        base = ln;
        run(32'h8000_0000 | 32'h3800_0000 | 32'h0000_00FF, 9'h000, 32'd0);
        chk("R3 disabled field", 32'(ln - base), 32'd1);
        wreg(3'd5, 32'h9000_0000);

        // R6 R5: confirm opcode after two address bytes, chip enable 1
        exp_ce = 2'b01;
        base = ln;
        run(32'h8000_0000 | 32'h4800_0000 | 32'h0008_0000 | 32'h0000_0060, 9'h1D0, 32'd0);
        chk("R6 cycle count", 32'(ln - base), 32'd4);
        chk("R6 confirm cycle", 32'(lg[8'(base + 3)]), {22'd0, 2'b10, 8'hD0});
        chk("R5 ce1 held", 32'(ce_bad), 32'd0);
        chk("R5 idle ce", 32'(nand_ce_n), 32'd3);
        exp_ce = 2'b10;
        wreg(3'd5, 32'h9000_0000);

        // R8: read phase of several lengths; R7 tWB spacing
        for (int k = 0; k < 3; k++) begin
            int len;
            len = (k == 0) ? 1 : (k == 1) ? 3 : 7;
            rbase = rn;
            run(32'h8000_0000 | 32'h4000_0000 | 32'h0400_0000 | 32'h0000_0090, 9'h000, 32'(len));
            chk("R8 read count", 32'(rn - rbase), 32'(len));
            for (int i = 0; i < len; i++)
                chk("R8 read byte", 32'(rbuf[6'(rbase + i)]), 32'(pat_rd(rbase + i)));
            if (k == 0)
                chk("R7 tWB spacing", 32'((t_re - t_we) >= 20 * TWB), 32'd1);
            rreg(3'd5, v); chk("R11 read irq", v, 32'h9000_0000);
            wreg(3'd5, 32'h9000_0000);
        end

        // R8: both direction bits set reads
        base = ln; rbase = rn;
        run(32'h8000_0000 | 32'h4000_0000 | 32'h0600_0000 | 32'h0000_0005, 9'h000, 32'd2);
        chk("R8 both bits read", 32'(rn - rbase), 32'd2);
        chk("R8 both bits no writes", 32'(ln - base), 32'd2);
        wreg(3'd5, 32'h9000_0000);

        // R9: write phase
        base = ln; wbase = widx;
        run(32'h8000_0000 | 32'h4800_0000 | 32'h0200_0000 | 32'h0000_0080, 9'h000, 32'd4);
        chk("R9 take count", 32'(widx - wbase), 32'd4);
        chk("R9 cycle count", 32'(ln - base), 32'd7);
        for (int i = 0; i < 4; i++)
            chk("R9 data cycle", 32'(lg[8'(base + 3 + i)]), {22'd0, 2'b00, pat_wr(wbase + i)});
        rreg(3'd5, v); chk("R9 irq", v, 32'h9000_0000);
        wreg(3'd5, 32'h9000_0000);

        // R10: zero length with read bit; no direction with nonzero length
        rbase = rn; rcb = rc;
        run(32'h8000_0000 | 32'h4000_0000 | 32'h0400_0000 | 32'h0000_0030, 9'h000, 32'd0);
        chk("R10 zero length reads", 32'(rc - rcb), 32'd0);
        rreg(3'd5, v); chk("R10 zero length irq", v, 32'h8000_0000);
        wreg(3'd5, 32'h9000_0000);
        base = ln; rcb = rc;
        run(32'h8000_0000 | 32'h4000_0000 | 32'h0000_0031, 9'h000, 32'd5);
        chk("R10 no direction cycles", 32'(ln - base), 32'd2);
        chk("R10 no direction reads", 32'(rc - rcb), 32'd0);
        rreg(3'd5, v); chk("R10 no direction irq", v, 32'h8000_0000);
        wreg(3'd5, 32'h9000_0000);

        // R7 R12: stall on busy flash, second control write ignored
        nand_rb = 1'b0;
        base = ln; rcb = rc;
        wreg(3'd4, 32'd2);
        wreg(3'd1, 32'd0);
        wreg(3'd0, 32'h8000_0000 | 32'h4000_0000 | 32'h0400_0000 | 32'h0000_0070);
        repeat (60) @(negedge clk);
        wreg(3'd0, 32'h8000_0000 | 32'h0000_0055);
        repeat (100) @(negedge clk);
        rreg(3'd6, v); chk("R12 busy during stall", v, 32'd1);
        rreg(3'd5, v); chk("R7 no done while busy flash", v, 32'd0);
        chk("R7 no read while busy flash", 32'(rc - rcb), 32'd0);
        rreg(3'd0, v); chk("R12 control unchanged", 32'(v[7:0]), 32'h70);
        nand_rb = 1'b1;
        wait_idle();
        chk("R7 reads after ready", 32'(rc - rcb), 32'd2);
        chk("R12 ignored write no cycles", 32'(ln - base), 32'd2);
        chk("R12 first opcode kept", 32'(lg[base[7:0]]), {22'd0, 2'b10, 8'h70});

        // R11: write-one-to-clear, per bit
        rreg(3'd5, v); chk("R11 both set", v, 32'h9000_0000);
        wreg(3'd5, 32'h0000_0000);
        rreg(3'd5, v); chk("R11 zero write keeps", v, 32'h9000_0000);
        wreg(3'd5, 32'h1000_0000);
        rreg(3'd5, v); chk("R11 clear data bit", v, 32'h8000_0000);
        chk("R11 irq pin high", 32'(irq), 32'd1);
        wreg(3'd5, 32'h8000_0000);
        rreg(3'd5, v); chk("R11 clear done bit", v, 32'd0);
        chk("R11 irq pin low", 32'(irq), 32'd0);

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule